// File: doc/BRIEF.md
# Port Pin-Change Interrupt Detector

This block watches the upper half of an 8-bit bidirectional port and raises a sticky change flag when any monitored pin that is configured as an input differs from a reference snapshot. The snapshot is not the previous clock's pin value. It is taken whenever software reads or writes the port. As a result, a pin that toggles and then settles at a new level keeps reporting a change until software touches the port. A combinational wake request is raised for as long as any monitored input pin disagrees with the snapshot, so a sleep controller can use it without waiting on the flag register.

The block also holds the port's output data latch. A full write loads the latch directly. Single-bit set and clear writes are read-modify-write operations: they start from the pin levels, not from the latch. It also generates the per-pin weak pull-up enables from one active-low global control bit and the direction bits. Pin inputs arrive already synchronized. Direction bits come from a direction register that sits outside this block.

Top module: `pin_change_monitor`

## Requirements
- R1: After synchronous reset, `chg_flag` is 0, `latch_q` is 0, the snapshot is 0, and the pull-up control reads "off", so `pullup_en` is 0 whatever the value of `dir_in`.
- R2: When any pin in 7..4 has `dir_in` = 1 (input) and differs from its snapshot bit, and neither `port_rd` nor `port_wr` is high in that cycle, `chg_flag` is 1 after the next rising clock edge.
- R3: Pins 3..0 never affect `chg_flag` or `wake_req`. A pin in 7..4 with `dir_in` = 0 (output) is left out of the comparison.
- R4: A cycle with `port_rd` or `port_wr` high copies `pin_in[7:4]` into the snapshot and does not set the flag. If the pins and directions then stay the same, the next cycle shows no mismatch.
- R5: `flag_clr` high with no mismatch clears `chg_flag` at the next edge. Without `flag_clr`, the flag holds its value.
- R6: If a set condition (as in R2) and `flag_clr` occur in the same cycle, the flag is 1 after the edge. A persisting mismatch therefore defeats the clear until a port access ends it.
- R7: `rd_data` always equals `pin_in`, which holds the pin levels.
- R8: `port_wr` loads `latch_q` at the edge, according to `wr_kind`. The value 2'b01 loads the pins with bit `wr_bit` set. The value 2'b10 loads the pins with bit `wr_bit` cleared. The values 2'b00 and 2'b11 load `wr_data`. Without `port_wr`, the latch holds.
- R9: `wake_req` is combinationally 1 exactly when some pin in 7..4 is an input and differs from the snapshot. It is independent of `chg_flag` and `flag_clr`.
- R10: `pu_wr` loads the active-low pull-up control from `pu_off_d`. `pullup_en[i]` = (control is 0) AND `dir_in[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Synchronized pin levels |
| dir_in | input | 8 | Per-pin direction, 1 = input |
| port_rd | input | 1 | Port read strobe |
| port_wr | input | 1 | Port write strobe |
| wr_kind | input | 2 | Write kind: 00/11 full, 01 bit set, 10 bit clear |
| wr_bit | input | 3 | Bit index for set/clear writes |
| wr_data | input | 8 | Full-write data |
| flag_clr | input | 1 | Software clear of the change flag |
| pu_wr | input | 1 | Load strobe for the pull-up control bit |
| pu_off_d | input | 1 | Pull-up control value, 1 = pull-ups off |
| rd_data | output | 8 | Port read data (pin levels) |
| latch_q | output | 8 | Output data latch |
| pullup_en | output | 8 | Per-pin weak pull-up enable |
| chg_flag | output | 1 | Sticky change flag |
| wake_req | output | 1 | Live mismatch / wake request |

## Verification
The bench targets four corner cases:

- A clear issued while a mismatch persists must leave the flag set. A design that let the clear win would lose changes that software has not yet acknowledged.
- A port access must end the mismatch. A design that compared against the previous clock would drop the flag's re-assertion, and one that failed to reload on writes would keep waking the device.
- Output-configured upper pins and all lower pins must never disturb the flag.
- Bit set and clear writes must start from the pin levels. A design that used the latch instead would differ whenever an input pin disagrees with its latch bit.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    localparam int PORT_W = 8;
    localparam int MON_LSB = 4;
    localparam int BIT_W = $clog2(PORT_W);

    typedef enum logic [1:0] {
        WK_FULL = 2'b00,
        WK_SET  = 2'b01,
        WK_CLR  = 2'b10,
        WK_ALT  = 2'b11
    } wr_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } access_t;

    function automatic logic [PORT_W-1:0] rmw_value(
        input logic [PORT_W-1:0] pins,
        input wr_kind_e          kind,
        input logic [BIT_W-1:0]  idx,
        input logic [PORT_W-1:0] data
    );
        logic [PORT_W-1:0] onehot;
        onehot = PORT_W'(1) << idx;
        case (kind)
            WK_SET:  return pins | onehot;
            WK_CLR:  return pins & ~onehot;
            default: return data;
        endcase
    endfunction

endpackage

// File: rtl/pcd_snap_cmp.sv
module pcd_snap_cmp #(
    parameter int MON_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MON_W-1:0] pins_mon,
    input  logic [MON_W-1:0] dir_mon,
    input  logic             access,
    output logic [MON_W-1:0] mismatch
);
    logic [MON_W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (access) begin
            snap_q <= pins_mon;
        end
    end

    for (genvar g = 0; g < MON_W; g++) begin : g_cmp
        assign mismatch[g] = dir_mon[g] & (pins_mon[g] ^ snap_q[g]);
    end
endmodule

// File: rtl/pcd_flag.sv
module pcd_flag (
    input  logic clk,
    input  logic rst,
    input  logic any_mm,
    input  logic access,
    input  logic clr,
    output logic flag
);
    logic set_c;

    assign set_c = any_mm & ~access;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_c) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pcd_out_latch.sv
module pcd_out_latch
    import pcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  wr_kind_e          kind,
    input  logic [BIT_W-1:0]  idx,
    input  logic [PORT_W-1:0] data,
    input  logic [PORT_W-1:0] pins,
    output logic [PORT_W-1:0] latch_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else if (wr) begin
            latch_q <= rmw_value(pins, kind, idx, data);
        end
    end
endmodule

// File: rtl/pcd_pullup.sv
module pcd_pullup #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pu_wr,
    input  logic              pu_off_d,
    input  logic [PORT_W-1:0] dir,
    output logic [PORT_W-1:0] pu_en
);
    logic pu_off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pu_off_q <= 1'b1;
        end else if (pu_wr) begin
            pu_off_q <= pu_off_d;
        end
    end

    for (genvar g = 0; g < PORT_W; g++) begin : g_pu
        assign pu_en[g] = ~pu_off_q & dir[g];
    end
endmodule

// File: rtl/pin_change_monitor.sv
module pin_change_monitor
    import pcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] pin_in,
    input  logic [PORT_W-1:0] dir_in,
    input  logic              port_rd,
    input  logic              port_wr,
    input  logic [1:0]        wr_kind,
    input  logic [BIT_W-1:0]  wr_bit,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              flag_clr,
    input  logic              pu_wr,
    input  logic              pu_off_d,
    output logic [PORT_W-1:0] rd_data,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] pullup_en,
    output logic              chg_flag,
    output logic              wake_req
);
    localparam int MON_W = PORT_W - MON_LSB;

    access_t          acc;
    logic             any_access;
    logic [MON_W-1:0] mm_vec;

    assign acc.rd     = port_rd;
    assign acc.wr     = port_wr;
    assign any_access = acc.rd | acc.wr;
    assign rd_data    = pin_in;
    assign wake_req   = |mm_vec;

    pcd_snap_cmp #(.MON_W(MON_W)) u_snap (
        .clk      (clk),
        .rst      (rst),
        .pins_mon (pin_in[PORT_W-1:MON_LSB]),
        .dir_mon  (dir_in[PORT_W-1:MON_LSB]),
        .access   (any_access),
        .mismatch (mm_vec)
    );

    pcd_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .any_mm (wake_req),
        .access (any_access),
        .clr    (flag_clr),
        .flag   (chg_flag)
    );

    pcd_out_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .wr      (acc.wr),
        .kind    (wr_kind_e'(wr_kind)),
        .idx     (wr_bit),
        .data    (wr_data),
        .pins    (pin_in),
        .latch_q (latch_q)
    );

    pcd_pullup #(.PORT_W(PORT_W)) u_pu (
        .clk      (clk),
        .rst      (rst),
        .pu_wr    (pu_wr),
        .pu_off_d (pu_off_d),
        .dir      (dir_in),
        .pu_en    (pullup_en)
    );
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
    parameter int PORT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [PORT_W-1:0] pin_in,
    input logic [PORT_W-1:0] dir_in,
    input logic              port_rd,
    input logic              port_wr,
    input logic              flag_clr,
    input logic [PORT_W-1:0] latch_q,
    input logic [PORT_W-1:0] pullup_en,
    input logic              chg_flag,
    input logic              wake_req
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!chg_flag && latch_q == '0 && pullup_en == '0));

    p_set_on_change_r2: assert property (@(posedge clk) disable iff (rst)
        (wake_req && !port_rd && !port_wr) |=> chg_flag);

    p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (rst)
        (!chg_flag && !wake_req) |=> !chg_flag);

    p_access_ends_mismatch_r4: assert property (@(posedge clk) disable iff (rst)
        (port_rd || port_wr) |=>
            (!($stable(pin_in) && $stable(dir_in)) || !wake_req));

    p_clear_works_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !wake_req) |=> !chg_flag);

    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && wake_req && !port_rd && !port_wr) |=> chg_flag);

    p_latch_holds_r8: assert property (@(posedge clk) disable iff (rst)
        !port_wr |=> $stable(latch_q));

    p_pullup_inputs_only_r10: assert property (@(posedge clk) disable iff (rst)
        (pullup_en & ~dir_in) == '0);
endmodule

bind pin_change_monitor pcd_checker u_chk (.*);

// File: tb/pin_change_monitor_test.sv
`timescale 1ns/1ps
module pin_change_monitor_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_in = '0, dir_in = '0, wr_data = '0;
    logic       port_rd = 0, port_wr = 0, flag_clr = 0, pu_wr = 0, pu_off_d = 1;
    logic [1:0] wr_kind = '0;
    logic [2:0] wr_bit = '0;
    logic [7:0] rd_data, latch_q, pullup_en;
    logic       chg_flag, wake_req;

    int nvec = 0, nbad = 0;
    logic [3:0] m_snap = '0;
    logic       m_flag = 0, m_pu_off = 1;
    logic [7:0] m_latch = '0;

    always #4 clk = ~clk;

    pin_change_monitor uut (.*);

    initial begin
        #2_000_000;
        nbad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] p, input logic [7:0] d, input logic rd,
                        input logic wr, input logic [1:0] k, input logic [2:0] b,
                        input logic [7:0] wd, input logic clr, input logic pw,
                        input logic pd);
        logic mm;
        logic [7:0] oh;
        string ft;
        @(negedge clk);
        pin_in = p; dir_in = d; port_rd = rd; port_wr = wr; wr_kind = k;
        wr_bit = b; wr_data = wd; flag_clr = clr; pu_wr = pw; pu_off_d = pd;
        #1;
        mm = (((p[7:4] ^ m_snap) & d[7:4]) != 4'h0);
        chk("R9 wake_req", {7'b0, wake_req}, {7'b0, mm});
        chk("R7 rd_data", rd_data, p);
        chk("R10 pullup_en", pullup_en, m_pu_off ? 8'h00 : d);
        ft = (mm && !(rd || wr)) ? (clr ? "R6 set beats clear" : "R2 flag set")
           : ((rd || wr) ? "R4 access no set" : (clr ? "R5 flag clear" : "R3 flag hold"));
        @(posedge clk);
        if (mm && !(rd || wr)) m_flag = 1;
        else if (clr) m_flag = 0;
        if (rd || wr) m_snap = p[7:4];
        oh = 8'h01 << b;
        if (wr) m_latch = (k == 2'b01) ? (p | oh) : (k == 2'b10) ? (p & ~oh) : wd;
        if (pw) m_pu_off = pd;
        #1;
        chk(ft, {7'b0, chg_flag}, {7'b0, m_flag});
        chk("R8 latch_q", latch_q, m_latch);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        dir_in = 8'hFF;
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        chk("R1 chg_flag after reset", {7'b0, chg_flag}, 8'h00);
        chk("R1 latch_q after reset", latch_q, 8'h00);
        chk("R1 pullups off after reset", pullup_en, 8'h00);
        chk("R1 no wake after reset", {7'b0, wake_req}, 8'h00);
        // R3: lower pins toggle with all inputs, no flag
        step(8'h0F, 8'hFF, 0,0,0,0,0,0,0,0);
        step(8'h05, 8'hFF, 0,0,0,0,0,0,0,0);
        // R3: pin 7 set as output, toggled
        step(8'h80, 8'h7F, 0,0,0,0,0,0,0,0);
        // R2: pin 5 input rises
        step(8'h20, 8'hFF, 0,0,0,0,0,0,0,0);
        // R6: clear while mismatch persists
        step(8'h20, 8'hFF, 0,0,0,0,0,1,0,0);
        // R4: read ends mismatch, then R5 clear works
        step(8'h20, 8'hFF, 1,0,0,0,0,0,0,0);
        step(8'h20, 8'hFF, 0,0,0,0,0,1,0,0);
        // R4 via write strobe, RMW bit-set R8
        step(8'h00, 8'hFF, 0,0,0,0,0,0,0,0);
        step(8'h00, 8'hFF, 0,1,2'b01,3'd6,8'hAA,1,0,0);
        // R10: pull-ups on
        step(8'h00, 8'hF0, 0,0,0,0,0,0,1,0);
        // near-exhaustive sweep
        for (int d = 0; d < 16; d++) begin
            for (int p = 0; p < 16; p++) begin
                for (int o = 0; o < 8; o++) begin
                    step({p[3:0], d[3:0] ^ o[3:0]}, {d[3:0], o[3:0] ^ p[3:0]},
                         o == 1, (o >= 2 && o <= 4) || o == 6,
                         (o == 3) ? 2'b01 : (o == 4) ? 2'b10 : (o == 6) ? 2'b11 : 2'b00,
                         p[2:0] ^ d[2:0], {p[3:0], d[3:0]},
                         o == 5 || o == 6, o == 7, p[0]);
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule